// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to the level-one data cache of one core in a snooping, MESI-coherent system. It tracks a single reservation for atomic read-modify-write sequences. Each cycle the core may present one cache operation: a load-linked, a store-conditional, or any other cache access. With it come the operation's physical address and the current MESI state of the addressed line. Independently, the coherence side may report a remote snoop that invalidates or downgrades a line.

A load-linked records its word address as the reservation and marks it live. If the line is not already Modified, the block also asks the cache controller to promote the line, which may need an ownership snoop on the bus. A store-conditional is granted only when three things hold: the reservation is still live, it names the same word, and the line is Modified at that moment. Every other cache operation, every store-conditional and every matching snoop drops the reservation. The outcome of a store-conditional is a done strobe and a pass bit. When the pass bit is set, the store goes ahead and the destination receives 1. When it is clear, the destination receives 0. No barrier logic is present, because the system is sequentially consistent.

All outputs are registered. They appear on the clock edge after the operation is presented.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op_kind 2'b01) on a line whose state is not Modified (line_mesi not 2'b11) raises promote_req for one cycle on the next edge, with promote_line equal to op_paddr shifted right by the line offset (5 bits by default). A load-linked on a Modified line raises no request.
- R2: A load-linked sets link_valid on the next edge and records the word address of op_paddr (the bits above the 2-bit word offset).
- R3: A store-conditional (op_kind 2'b10) whose line is not Modified gives sc_done=1 and sc_pass=0 on the next edge.
- R4: A store-conditional whose word address differs from the recorded one fails (sc_pass=0), even when it falls in the same line.
- R5: Any other valid cache operation (op_kind 2'b00 or 2'b11) clears link_valid on the next edge.
- R6: A store-conditional with a live reservation, a matching word address and a Modified line gives sc_done=1 and sc_pass=1 on the next edge. sc_pass=1 means the store is performed and 1 is returned.
- R7: Every store-conditional clears link_valid, whether it passes or fails, so a second store-conditional fails.
- R8: A snoop (snp_valid) whose line address equals the reserved line clears link_valid on the next edge. A snoop to another line leaves it unchanged.
- R9: When a snoop to the reserved line falls in the same cycle as a store-conditional, the store-conditional fails. When it falls in the same cycle as a load-linked, the new reservation from the load-linked is kept.
- R10: Synchronous reset clears link_valid, promote_req, sc_done and sc_pass.
- R11: A cycle with neither a valid operation nor a snoop leaves link_valid unchanged and keeps all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A cache operation is presented this cycle |
| op_kind | input | 2 | 00 other, 01 load-linked, 10 store-conditional, 11 other |
| op_paddr | input | PA_W | Physical byte address of the operation |
| line_mesi | input | 2 | State of the addressed line: 00 I, 01 S, 10 E, 11 M |
| snp_valid | input | 1 | Remote invalidate or downgrade this cycle |
| snp_paddr | input | PA_W | Physical address of the snooped line |
| promote_req | output | 1 | Request to bring the line to Modified |
| promote_line | output | PA_W-LINE_OFF_W | Line address to promote |
| sc_done | output | 1 | A store-conditional has been judged |
| sc_pass | output | 1 | Store-conditional succeeded (store performed, returns 1) |
| link_valid | output | 1 | Reservation is live |

## Verification
A remote snoop can reach the reserved line in the same cycle as a local store-conditional or load-linked. The vector table sets up a live reservation, then presents the snoop together with the store-conditional. The store-conditional must report failure, and the reservation must drop. A second vector pairs a snoop to a freshly linked line with the load-linked itself. The reservation must survive, and a following store-conditional must pass.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    MESI_I = 2'b00,
    MESI_S = 2'b01,
    MESI_E = 2'b10,
    MESI_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    OPK_PLAIN = 2'b00,
    OPK_LL    = 2'b01,
    OPK_SC    = 2'b10,
    OPK_RSVD  = 2'b11
  } opk_e;
endpackage

// File: rtl/llsc_op_classify.sv
module llsc_op_classify
  import llsc_pkg::*;
(
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  input  logic [1:0] line_mesi,
  output logic       is_ll,
  output logic       is_sc,
  output logic       is_other,
  output logic       line_mod
);
  opk_e  kind;
  mesi_e st;

  always_comb begin
    kind     = opk_e'(op_kind);
    st       = mesi_e'(line_mesi);
    is_ll    = 1'b0;
    is_sc    = 1'b0;
    is_other = 1'b0;
    if (op_valid) begin
      unique case (kind)
        OPK_LL:  is_ll    = 1'b1;
        OPK_SC:  is_sc    = 1'b1;
        default: is_other = 1'b1;
      endcase
    end
    line_mod = (st == MESI_M);
  end
endmodule

// File: rtl/llsc_link_tracker.sv
module llsc_link_tracker #(
  parameter int PA_W       = 32,
  parameter int WORD_OFF_W = 2,
  parameter int LINE_OFF_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     is_ll,
  input  logic                     is_sc,
  input  logic                     is_other,
  input  logic [PA_W-1:0]          op_paddr,
  input  logic                     snp_valid,
  input  logic [PA_W-1:0]          snp_paddr,
  output logic                     link_valid,
  output logic [PA_W-WORD_OFF_W-1:0] link_waddr,
  output logic                     snoop_kill,
  output logic                     word_match
);
  localparam int WA_W    = PA_W - WORD_OFF_W;
  localparam int LA_W    = PA_W - LINE_OFF_W;
  localparam int LSHIFT  = LINE_OFF_W - WORD_OFF_W;

  logic [WA_W-1:0] op_waddr;
  logic [LA_W-1:0] link_line;
  logic [LA_W-1:0] snp_line;

  assign op_waddr = op_paddr[PA_W-1:WORD_OFF_W];
  assign snp_line = snp_paddr[PA_W-1:LINE_OFF_W];

  generate
    if (LSHIFT == 0) begin : g_line_is_word
      assign link_line = link_waddr;
    end else begin : g_line_from_word
      assign link_line = link_waddr[WA_W-1:LSHIFT];
    end
  endgenerate

  assign snoop_kill = snp_valid && link_valid && (snp_line == link_line);
  assign word_match = (op_waddr == link_waddr);

  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_waddr <= '0;
    end else if (is_ll) begin
      link_valid <= 1'b1;
      link_waddr <= op_waddr;
    end else if (is_sc || is_other || snoop_kill) begin
      link_valid <= 1'b0;
    end
  end

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> !link_valid);
  assert_ll_sets_link_R2: assert property (@(posedge clk) disable iff (rst)
    is_ll |=> (link_valid && link_waddr == $past(op_waddr)));
  assert_other_clears_R5: assert property (@(posedge clk) disable iff (rst)
    is_other |=> !link_valid);
  assert_sc_clears_R7: assert property (@(posedge clk) disable iff (rst)
    is_sc |=> !link_valid);
  assert_snoop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (snoop_kill && !is_ll) |=> !link_valid);
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (!is_ll && !is_sc && !is_other && !snp_valid) |=> $stable(link_valid));
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge (
  input  logic clk,
  input  logic rst,
  input  logic is_sc,
  input  logic link_valid,
  input  logic snoop_kill,
  input  logic word_match,
  input  logic line_mod,
  output logic sc_done,
  output logic sc_pass
);
  logic grant;

  assign grant = is_sc && link_valid && !snoop_kill && word_match && line_mod;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_done <= 1'b0;
      sc_pass <= 1'b0;
    end else begin
      sc_done <= is_sc;
      sc_pass <= grant;
    end
  end

  assert_sc_needs_mod_R3: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !line_mod) |=> (sc_done && !sc_pass));
  assert_sc_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !word_match) |=> !sc_pass);
  assert_sc_snoop_R9: assert property (@(posedge clk) disable iff (rst)
    (is_sc && snoop_kill) |=> !sc_pass);
  assert_pass_has_done_R6: assert property (@(posedge clk) disable iff (rst)
    sc_pass |-> sc_done);
endmodule

// File: rtl/llsc_promote_gen.sv
module llsc_promote_gen #(
  parameter int PA_W       = 32,
  parameter int LINE_OFF_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       is_ll,
  input  logic                       line_mod,
  input  logic [PA_W-1:0]            op_paddr,
  output logic                       promote_req,
  output logic [PA_W-LINE_OFF_W-1:0] promote_line
);
  always_ff @(posedge clk) begin
    if (rst) begin
      promote_req  <= 1'b0;
      promote_line <= '0;
    end else begin
      promote_req <= is_ll && !line_mod;
      if (is_ll) promote_line <= op_paddr[PA_W-1:LINE_OFF_W];
    end
  end

  assert_promote_R1: assert property (@(posedge clk) disable iff (rst)
    (is_ll && !line_mod) |=> promote_req);
  assert_no_promote_mod_R1: assert property (@(posedge clk) disable iff (rst)
    (is_ll && line_mod) |=> !promote_req);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int PA_W       = 32,
  parameter int WORD_OFF_W = 2,
  parameter int LINE_OFF_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       op_valid,
  input  logic [1:0]                 op_kind,
  input  logic [PA_W-1:0]            op_paddr,
  input  logic [1:0]                 line_mesi,
  input  logic                       snp_valid,
  input  logic [PA_W-1:0]            snp_paddr,
  output logic                       promote_req,
  output logic [PA_W-LINE_OFF_W-1:0] promote_line,
  output logic                       sc_done,
  output logic                       sc_pass,
  output logic                       link_valid
);
  localparam int WA_W = PA_W - WORD_OFF_W;

  logic            is_ll, is_sc, is_other, line_mod;
  logic            snoop_kill, word_match;
  logic [WA_W-1:0] link_waddr;

  llsc_op_classify u_classify (
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .line_mesi(line_mesi),
    .is_ll    (is_ll),
    .is_sc    (is_sc),
    .is_other (is_other),
    .line_mod (line_mod)
  );

  llsc_link_tracker #(
    .PA_W(PA_W), .WORD_OFF_W(WORD_OFF_W), .LINE_OFF_W(LINE_OFF_W)
  ) u_link (
    .clk       (clk),
    .rst       (rst),
    .is_ll     (is_ll),
    .is_sc     (is_sc),
    .is_other  (is_other),
    .op_paddr  (op_paddr),
    .snp_valid (snp_valid),
    .snp_paddr (snp_paddr),
    .link_valid(link_valid),
    .link_waddr(link_waddr),
    .snoop_kill(snoop_kill),
    .word_match(word_match)
  );

  llsc_sc_judge u_judge (
    .clk       (clk),
    .rst       (rst),
    .is_sc     (is_sc),
    .link_valid(link_valid),
    .snoop_kill(snoop_kill),
    .word_match(word_match),
    .line_mod  (line_mod),
    .sc_done   (sc_done),
    .sc_pass   (sc_pass)
  );

  llsc_promote_gen #(
    .PA_W(PA_W), .LINE_OFF_W(LINE_OFF_W)
  ) u_promote (
    .clk         (clk),
    .rst         (rst),
    .is_ll       (is_ll),
    .line_mod    (line_mod),
    .op_paddr    (op_paddr),
    .promote_req (promote_req),
    .promote_line(promote_line)
  );

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!sc_done && !promote_req));
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int PA_W = 32;
  localparam int LOFF = 5;

  typedef struct packed {
    logic        ov;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [1:0]  st;
    logic        sv;
    logic [31:0] saddr;
    logic [3:0]  exp;   // {done, pass, promote, link}
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic ov, logic [1:0] kind, logic [31:0] addr,
                              logic [1:0] st, logic sv, logic [31:0] saddr,
                              logic [3:0] exp, logic [3:0] req);
    vec_t v;
    v.ov = ov; v.kind = kind; v.addr = addr; v.st = st;
    v.sv = sv; v.saddr = saddr; v.exp = exp; v.req = req;
    return v;
  endfunction

  localparam logic [31:0] A  = 32'h0000_1040;
  localparam logic [31:0] A4 = 32'h0000_1044;
  localparam logic [31:0] B  = 32'h0000_2080;
  localparam logic [31:0] B8 = 32'h0000_2088;
  localparam logic [31:0] C  = 32'h0000_3000;
  localparam int NV = 24;

  localparam vec_t VT [0:NV-1] = '{
    mk(1'b0, 2'b00, 32'h0, 2'b00, 1'b0, 32'h0, 4'b0000, 4'd11), // R11 idle
    mk(1'b1, 2'b01, A,  2'b01, 1'b0, 32'h0, 4'b0011, 4'd1),     // R1 LL on S promotes
    mk(1'b1, 2'b10, A,  2'b11, 1'b0, 32'h0, 4'b1100, 4'd6),     // R6 pass
    mk(1'b1, 2'b01, A,  2'b11, 1'b0, 32'h0, 4'b0001, 4'd1),     // R1 LL on M no promote
    mk(1'b1, 2'b10, A,  2'b10, 1'b0, 32'h0, 4'b1000, 4'd3),     // R3 E fails
    mk(1'b1, 2'b01, A,  2'b10, 1'b0, 32'h0, 4'b0011, 4'd2),     // R2
    mk(1'b1, 2'b10, A4, 2'b11, 1'b0, 32'h0, 4'b1000, 4'd4),     // R4 other word
    mk(1'b1, 2'b01, B,  2'b11, 1'b0, 32'h0, 4'b0001, 4'd2),     // R2
    mk(1'b1, 2'b00, C,  2'b11, 1'b0, 32'h0, 4'b0000, 4'd5),     // R5 plain op
    mk(1'b1, 2'b10, B,  2'b11, 1'b0, 32'h0, 4'b1000, 4'd5),     // R5 link gone
    mk(1'b1, 2'b01, B,  2'b00, 1'b0, 32'h0, 4'b0011, 4'd1),     // R1 LL on I
    mk(1'b0, 2'b00, 32'h0, 2'b00, 1'b1, B8, 4'b0000, 4'd8),     // R8 snoop hit
    mk(1'b1, 2'b10, B,  2'b11, 1'b0, 32'h0, 4'b1000, 4'd8),     // R8 SC fails
    mk(1'b1, 2'b01, A,  2'b11, 1'b0, 32'h0, 4'b0001, 4'd2),     // R2
    mk(1'b0, 2'b00, 32'h0, 2'b00, 1'b1, C,  4'b0001, 4'd8),     // R8 other line
    mk(1'b1, 2'b10, A,  2'b11, 1'b0, 32'h0, 4'b1100, 4'd6),     // R6
    mk(1'b1, 2'b10, A,  2'b11, 1'b0, 32'h0, 4'b1000, 4'd7),     // R7 second SC
    mk(1'b1, 2'b01, A,  2'b11, 1'b0, 32'h0, 4'b0001, 4'd2),     // R2
    mk(1'b1, 2'b10, A,  2'b11, 1'b1, A4, 4'b1000, 4'd9),        // R9 snoop with SC
    mk(1'b1, 2'b01, A,  2'b11, 1'b0, 32'h0, 4'b0001, 4'd2),     // R2
    mk(1'b1, 2'b01, B,  2'b01, 1'b1, B8, 4'b0011, 4'd9),        // R9 LL beats snoop
    mk(1'b1, 2'b10, B,  2'b11, 1'b0, 32'h0, 4'b1100, 4'd9),     // R9 then passes
    mk(1'b1, 2'b01, A,  2'b11, 1'b0, 32'h0, 4'b0001, 4'd2),     // R2
    mk(1'b1, 2'b11, C,  2'b11, 1'b0, 32'h0, 4'b0000, 4'd5)      // R5 kind 11
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [PA_W-1:0] op_paddr = '0;
  logic [1:0] line_mesi = 2'b00;
  logic snp_valid = 1'b0;
  logic [PA_W-1:0] snp_paddr = '0;
  logic promote_req, sc_done, sc_pass, link_valid;
  logic [PA_W-LOFF-1:0] promote_line;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  llsc_monitor #(.PA_W(PA_W), .WORD_OFF_W(2), .LINE_OFF_W(LOFF)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_paddr(op_paddr), .line_mesi(line_mesi), .snp_valid(snp_valid),
    .snp_paddr(snp_paddr), .promote_req(promote_req),
    .promote_line(promote_line), .sc_done(sc_done), .sc_pass(sc_pass),
    .link_valid(link_valid)
  );

  function automatic logic [3:0] outs();
    return {sc_done, sc_pass, promote_req, link_valid};
  endfunction

  task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (done,pass,prom,link)", tag, act, exp);
    end
  endtask

  task automatic drive(logic ov, logic [1:0] k, logic [31:0] a, logic [1:0] s,
                       logic sv, logic [31:0] sa);
    op_valid = ov; op_kind = k; op_paddr = a; line_mesi = s;
    snp_valid = sv; snp_paddr = sa;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check4("R10 reset state", outs(), 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].ov, VT[i].kind, VT[i].addr, VT[i].st, VT[i].sv, VT[i].saddr);
      check4($sformatf("R%0d vector %0d", VT[i].req, i), outs(), VT[i].exp);
    end

    // R1 promote_line carries the line address
    drive(1'b1, 2'b01, B8, 2'b01, 1'b0, 32'h0);
    checks++;
    if (promote_line !== B8[31:LOFF]) begin
      errors++;
      $display("FAIL R1 promote_line actual=%h expected=%h", promote_line, B8[31:LOFF]);
    end

    // R10 reset drops a live reservation
    drive(1'b1, 2'b01, A, 2'b11, 1'b0, 32'h0);
    check4("R10 link before reset", outs(), 4'b0001);
    rst = 1'b1;
    drive(1'b1, 2'b10, A, 2'b11, 1'b0, 32'h0);
    check4("R10 during reset", outs(), 4'b0000);
    rst = 1'b0;
    drive(1'b1, 2'b10, A, 2'b11, 1'b0, 32'h0);
    check4("R10 SC after reset fails", outs(), 4'b1000);

    // R11 idle cycles keep a reservation
    drive(1'b1, 2'b01, C, 2'b11, 1'b0, 32'h0);
    drive(1'b0, 2'b00, 32'h0, 2'b00, 1'b0, 32'h0);
    drive(1'b0, 2'b00, 32'h0, 2'b00, 1'b0, 32'h0);
    check4("R11 idle keeps link", outs(), 4'b0001);
    drive(1'b1, 2'b10, C, 2'b11, 1'b0, 32'h0);
    check4("R6 pass after idle", outs(), 4'b1100);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule